// File: doc/BRIEF.md
# Lazy FP Stacking Fault Pender

This block settles what happens to a fault raised while the processor is lazily saving floating-point registers to the stack. The usual escalation rules look at the live enable and priority state. Here the choice to escalate to HardFault is made from "ready" bits that were captured into a saved context word when the stack frame was built. There are two copies of that word, one secure and one non-secure. The block reads the right copy for each fault, picks the final vector and bank, and then does one of four things: it pends the vector, drops the request, flags it as illegal, or declares lockup.

Each request is decoded combinationally and committed on the rising clock edge while `req_valid` is high. The results appear one cycle later as single-cycle strobes: a pend strobe with the final exception number and bank, a forced-escalation strobe that sets the HardFault status forced bit, an ignore strobe and an illegal strobe. A sticky lockup flag completes the set. A pend strobe also tells the surrounding controller to recompute its priorities. No interrupt line is raised.

Top module: `lfp_fault_pender`

## Requirements
- R1: A DebugMonitor request (exception 12) is dropped when the monitor-ready bit (bit 5) of the secure context word is clear. The only effect is `ignore_stb`. When that bit is set, the request resolves like any non-escalating fault on bank 0.
- R2: A MemManage (4) or UsageFault (6) request escalates when its ready bit is clear. The MemManage ready bit is bit 1 and the UsageFault ready bit is bit 2, both taken from the context word that `req_sec` selects (1 = secure copy).
- R3: A BusFault (5) or SecureFault (7) request escalates when its ready bit is clear. The BusFault ready bit is bit 3 and the SecureFault ready bit is bit 4, and both are always read from the secure context word.
- R4: An escalated request resolves to HardFault (3). It uses bank 1 (secure) when `sec_ext` is high and either the original fault targeted Secure or `hf_ns_route` is low. Otherwise it uses bank 0. A request that does not escalate keeps its own number, and uses bank 1 only when it is banked and `req_sec` is high.
- R5: Every escalation that does not lock up pulses `forced_stb`, whether or not HardFault was already pending. When `forced_stb` pulses, `pend_exc` reads 3.
- R6: The final vector is blocked when it is disabled or when `exec_prio` is less than or equal to its group priority. If it is blocked and the HardFault-ready bit (bit 0) of the secure context word is clear, `lockup` is set, and neither `pend_stb` nor `forced_stb` pulses. If it is blocked but that bit is set, the request resolves normally.
- R7: `pend_stb` pulses in the cycle after the committed request, and only when the final vector's pending bit in its bank is clear.
- R8: A request is illegal when its exception number is not 4, 5, 6, 7 or 12, or is at or above NUM_EXC, or has `req_sec` high on an exception that is not banked. Among the accepted numbers only 4 and 6 are banked. An illegal request gives only `illegal_stb`.
- R9: `lockup` stays high once set, through later requests, until reset.
- R10: After reset, every strobe, `lockup`, `pend_exc` and `pend_bank` are zero.
- R11: For a non-banked exception, the original target state is `tgt_sec[exc]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Commit the request this cycle |
| req_exc | input | EXC_W | Exception number of the request |
| req_sec | input | 1 | Secure bank of a banked exception |
| ctx_s | input | 6 | Saved context ready bits, secure copy |
| ctx_ns | input | 6 | Saved context ready bits, non-secure copy |
| sec_ext | input | 1 | Security extension present |
| hf_ns_route | input | 1 | HardFault and BusFault routed to non-secure |
| tgt_sec | input | NUM_EXC | Per-exception target state for non-banked exceptions |
| vec_en_s | input | NUM_EXC | Vector enables, bank 1 |
| vec_en_ns | input | NUM_EXC | Vector enables, bank 0 |
| vec_pend_s | input | NUM_EXC | Pending bits, bank 1 |
| vec_pend_ns | input | NUM_EXC | Pending bits, bank 0 |
| vec_gprio_s | input | NUM_EXC*PRIO_W | Group priorities, bank 1 |
| vec_gprio_ns | input | NUM_EXC*PRIO_W | Group priorities, bank 0 |
| exec_prio | input | PRIO_W+1 | Current execution priority |
| pend_stb | output | 1 | Set pending on the final vector and recompute |
| pend_exc | output | EXC_W | Final exception number |
| pend_bank | output | 1 | Final bank (1 = secure) |
| forced_stb | output | 1 | Set the HardFault forced status bit |
| ignore_stb | output | 1 | Request dropped |
| illegal_stb | output | 1 | Request rejected as illegal |
| lockup | output | 1 | Sticky lockup |

## Verification
Escalation and the blocked-vector test act in the same cycle. An escalated fault whose HardFault vector is disabled or outranked must lock up only when the secure HardFault-ready bit is clear. The bench provokes this with directed cases that disable HardFault while clearing or setting that bit. It also uses random requests that mix clear ready bits, random enables and random priorities. It judges each outcome against a bench function that picks between lockup, forced escalation without pend (HardFault already pending) and forced escalation with pend.

// File: rtl/lfp_pkg.sv
package lfp_pkg;
  localparam int CTX_W    = 6;
  localparam int RDY_HF   = 0;
  localparam int RDY_MM   = 1;
  localparam int RDY_UF   = 2;
  localparam int RDY_BF   = 3;
  localparam int RDY_SF   = 4;
  localparam int RDY_MON  = 5;

  localparam int EXC_HARD = 3;
  localparam int EXC_MEM  = 4;
  localparam int EXC_BUS  = 5;
  localparam int EXC_USG  = 6;
  localparam int EXC_SECF = 7;
  localparam int EXC_MON  = 12;

  // exceptions that have one copy per security state
  localparam logic [15:0] BANKED_MASK = 16'b1100_1000_0101_1000;

  function automatic logic is_banked(input int unsigned exc);
    return (exc < 16) ? BANKED_MASK[exc] : 1'b0;
  endfunction
endpackage

// File: rtl/lfp_classify.sv
module lfp_classify
  import lfp_pkg::*;
#(
  parameter int NUM_EXC = 16,
  parameter int EXC_W   = 5
) (
  input  logic [EXC_W-1:0] exc,
  input  logic             sec,
  input  logic [CTX_W-1:0] ctx_s,
  input  logic [CTX_W-1:0] ctx_ns,
  output logic             illegal,
  output logic             ignore,
  output logic             escalate,
  output logic             banked
);
  logic [CTX_W-1:0] sel_ctx;
  logic             out_of_range;
  logic             unused_ctx;

  assign sel_ctx      = sec ? ctx_s : ctx_ns;
  assign unused_ctx   = ^{sel_ctx[RDY_HF], sel_ctx[RDY_BF], sel_ctx[RDY_SF], sel_ctx[RDY_MON]};
  assign banked       = is_banked(int'(exc));
  assign out_of_range = int'(exc) >= NUM_EXC;

  always_comb begin
    illegal  = 1'b0;
    ignore   = 1'b0;
    escalate = 1'b0;
    case (int'(exc))
      EXC_MON:  ignore   = !ctx_s[RDY_MON];
      EXC_MEM:  escalate = !sel_ctx[RDY_MM];
      EXC_USG:  escalate = !sel_ctx[RDY_UF];
      EXC_BUS:  escalate = !ctx_s[RDY_BF];
      EXC_SECF: escalate = !ctx_s[RDY_SF];
      default:  illegal  = 1'b1;
    endcase
    if (out_of_range || (sec && !banked)) illegal = 1'b1;
    if (illegal) begin
      ignore   = 1'b0;
      escalate = 1'b0;
    end
  end
endmodule

// File: rtl/lfp_target.sv
module lfp_target
  import lfp_pkg::*;
#(
  parameter int NUM_EXC = 16,
  parameter int EXC_W   = 5
) (
  input  logic [EXC_W-1:0]   exc,
  input  logic               sec,
  input  logic               banked,
  input  logic               escalate,
  input  logic [NUM_EXC-1:0] tgt_sec,
  input  logic               sec_ext,
  input  logic               hf_ns_route,
  output logic [EXC_W-1:0]   fin_exc,
  output logic               fin_bank
);
  localparam int IDX_W = (NUM_EXC > 1) ? $clog2(NUM_EXC) : 1;

  logic [IDX_W-1:0] idx;
  logic             orig_secure;

  assign idx = exc[IDX_W-1:0];

  always_comb begin
    orig_secure = banked ? sec : tgt_sec[idx];
    if (escalate) begin
      fin_exc  = EXC_W'(EXC_HARD);
      fin_bank = sec_ext && (orig_secure || !hf_ns_route);
    end else begin
      fin_exc  = exc;
      fin_bank = banked && sec;
    end
  end
endmodule

// File: rtl/lfp_gate.sv
module lfp_gate #(
  parameter int NUM_EXC = 16,
  parameter int EXC_W   = 5,
  parameter int PRIO_W  = 8
) (
  input  logic [EXC_W-1:0]          fin_exc,
  input  logic                      fin_bank,
  input  logic [NUM_EXC-1:0]        vec_en_s,
  input  logic [NUM_EXC-1:0]        vec_en_ns,
  input  logic [NUM_EXC-1:0]        vec_pend_s,
  input  logic [NUM_EXC-1:0]        vec_pend_ns,
  input  logic [NUM_EXC*PRIO_W-1:0] vec_gprio_s,
  input  logic [NUM_EXC*PRIO_W-1:0] vec_gprio_ns,
  input  logic [PRIO_W:0]           exec_prio,
  output logic                      blocked,
  output logic                      already_pend
);
  localparam int IDX_W = (NUM_EXC > 1) ? $clog2(NUM_EXC) : 1;

  logic [IDX_W-1:0]  idx;
  logic              en;
  logic [PRIO_W-1:0] gprio;

  assign idx = fin_exc[IDX_W-1:0];

  always_comb begin
    en           = fin_bank ? vec_en_s[idx]   : vec_en_ns[idx];
    already_pend = fin_bank ? vec_pend_s[idx] : vec_pend_ns[idx];
    gprio        = fin_bank ? vec_gprio_s[int'(idx)*PRIO_W +: PRIO_W]
                            : vec_gprio_ns[int'(idx)*PRIO_W +: PRIO_W];
    blocked      = !en || (exec_prio <= {1'b0, gprio});
  end
endmodule

// File: rtl/lfp_fault_pender.sv
module lfp_fault_pender
  import lfp_pkg::*;
#(
  parameter int NUM_EXC = 16,
  parameter int EXC_W   = 5,
  parameter int PRIO_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [EXC_W-1:0]          req_exc,
  input  logic                      req_sec,
  input  logic [5:0]                ctx_s,
  input  logic [5:0]                ctx_ns,
  input  logic                      sec_ext,
  input  logic                      hf_ns_route,
  input  logic [NUM_EXC-1:0]        tgt_sec,
  input  logic [NUM_EXC-1:0]        vec_en_s,
  input  logic [NUM_EXC-1:0]        vec_en_ns,
  input  logic [NUM_EXC-1:0]        vec_pend_s,
  input  logic [NUM_EXC-1:0]        vec_pend_ns,
  input  logic [NUM_EXC*PRIO_W-1:0] vec_gprio_s,
  input  logic [NUM_EXC*PRIO_W-1:0] vec_gprio_ns,
  input  logic [PRIO_W:0]           exec_prio,
  output logic                      pend_stb,
  output logic [EXC_W-1:0]          pend_exc,
  output logic                      pend_bank,
  output logic                      forced_stb,
  output logic                      ignore_stb,
  output logic                      illegal_stb,
  output logic                      lockup
);
  logic             illegal, ignore, escalate, banked;
  logic [EXC_W-1:0] fin_exc;
  logic             fin_bank;
  logic             blocked, already_pend;

  logic             go, lock_hit;
  logic             pend_n, forced_n, ignore_n, illegal_n, lockup_n;

  lfp_classify #(.NUM_EXC(NUM_EXC), .EXC_W(EXC_W)) u_classify (
    .exc(req_exc), .sec(req_sec), .ctx_s(ctx_s), .ctx_ns(ctx_ns),
    .illegal(illegal), .ignore(ignore), .escalate(escalate), .banked(banked)
  );

  lfp_target #(.NUM_EXC(NUM_EXC), .EXC_W(EXC_W)) u_target (
    .exc(req_exc), .sec(req_sec), .banked(banked), .escalate(escalate),
    .tgt_sec(tgt_sec), .sec_ext(sec_ext), .hf_ns_route(hf_ns_route),
    .fin_exc(fin_exc), .fin_bank(fin_bank)
  );

  lfp_gate #(.NUM_EXC(NUM_EXC), .EXC_W(EXC_W), .PRIO_W(PRIO_W)) u_gate (
    .fin_exc(fin_exc), .fin_bank(fin_bank),
    .vec_en_s(vec_en_s), .vec_en_ns(vec_en_ns),
    .vec_pend_s(vec_pend_s), .vec_pend_ns(vec_pend_ns),
    .vec_gprio_s(vec_gprio_s), .vec_gprio_ns(vec_gprio_ns),
    .exec_prio(exec_prio),
    .blocked(blocked), .already_pend(already_pend)
  );

  // next-state
  always_comb begin
    go        = req_valid && !illegal && !ignore;
    lock_hit  = go && blocked && !ctx_s[RDY_HF];
    pend_n    = go && !lock_hit && !already_pend;
    forced_n  = go && !lock_hit && escalate;
    ignore_n  = req_valid && ignore;
    illegal_n = req_valid && illegal;
    lockup_n  = lockup || lock_hit;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_stb    <= 1'b0;
      forced_stb  <= 1'b0;
      ignore_stb  <= 1'b0;
      illegal_stb <= 1'b0;
      lockup      <= 1'b0;
    end else begin
      pend_stb    <= pend_n;
      forced_stb  <= forced_n;
      ignore_stb  <= ignore_n;
      illegal_stb <= illegal_n;
      lockup      <= lockup_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_exc  <= '0;
      pend_bank <= 1'b0;
    end else if (go) begin
      pend_exc  <= fin_exc;
      pend_bank <= fin_bank;
    end
  end
endmodule

// File: rtl/lfp_fault_pender_chk.sv
module lfp_fault_pender_chk #(
  parameter int EXC_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [EXC_W-1:0] req_exc,
  input logic             pend_stb,
  input logic [EXC_W-1:0] pend_exc,
  input logic             forced_stb,
  input logic             ignore_stb,
  input logic             illegal_stb,
  input logic             lockup
);
  // R7 R1 R8: at most one outcome per request
  a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pend_stb, ignore_stb, illegal_stb}));

  // R5: a forced strobe always reports HardFault
  a_r5_forced_is_hard: assert property (@(posedge clk) disable iff (!rst_n)
    forced_stb |-> (pend_exc == EXC_W'(3)) && !ignore_stb && !illegal_stb);

  // R9: lockup is sticky
  a_r9_lockup_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lockup |=> lockup);

  // R7: strobes only follow a committed request
  a_r7_strobe_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid == 1'b0 |=> !pend_stb && !forced_stb && !ignore_stb && !illegal_stb);

  // R1: ignore only for DebugMonitor
  a_r1_ignore_monitor: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_exc != EXC_W'(12)) |=> !ignore_stb);

  // R4: without escalation the pended number is the requested one
  a_r4_keep_number: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (pend_stb && !forced_stb) |-> (pend_exc == $past(req_exc)));
endmodule

bind lfp_fault_pender lfp_fault_pender_chk #(.EXC_W(EXC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_exc(req_exc),
  .pend_stb(pend_stb), .pend_exc(pend_exc), .forced_stb(forced_stb),
  .ignore_stb(ignore_stb), .illegal_stb(illegal_stb), .lockup(lockup)
);

// File: tb/lfp_fault_pender_bench.sv
`timescale 1ns/1ps
module lfp_fault_pender_bench;
  localparam int N  = 16;
  localparam int XW = 5;
  localparam int PW = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_valid;
  logic [XW-1:0]   exc;
  logic            sec;
  logic [5:0]      cs, cn;
  logic            sx, hn;
  logic [N-1:0]    tg, ens, enn, pds, pdn;
  logic [N*PW-1:0] gps, gpn;
  logic [PW:0]     ep;

  logic            pend_stb, pend_bank, forced_stb, ignore_stb, illegal_stb, lockup;
  logic [XW-1:0]   pend_exc;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic          e_pend, e_forced, e_ign, e_ill, e_lock, e_bank;
  logic [XW-1:0] e_exc;
  string         e_tag;

  always #2.5 clk = ~clk;

  lfp_fault_pender #(.NUM_EXC(N), .EXC_W(XW), .PRIO_W(PW)) u_lfp_fault_pender (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_exc(exc), .req_sec(sec),
    .ctx_s(cs), .ctx_ns(cn), .sec_ext(sx), .hf_ns_route(hn), .tgt_sec(tg),
    .vec_en_s(ens), .vec_en_ns(enn), .vec_pend_s(pds), .vec_pend_ns(pdn),
    .vec_gprio_s(gps), .vec_gprio_ns(gpn), .exec_prio(ep),
    .pend_stb(pend_stb), .pend_exc(pend_exc), .pend_bank(pend_bank),
    .forced_stb(forced_stb), .ignore_stb(ignore_stb), .illegal_stb(illegal_stb),
    .lockup(lockup)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic predict();
    logic bk, esc, ts, en, blk, pd;
    logic [PW-1:0] gp;
    logic [5:0] sc;
    int fe;
    e_pend = 0; e_forced = 0; e_ign = 0; e_ill = 0; e_bank = 0; e_exc = 'x; e_tag = "R7";
    bk  = (exc == 4) || (exc == 6);
    esc = 0;
    sc  = sec ? cs : cn;
    if (!(exc inside {5'd4, 5'd5, 5'd6, 5'd7, 5'd12}) || (sec && !bk)) begin
      e_ill = 1; e_tag = "R8";
    end else if (exc == 12 && !cs[5]) begin
      e_ign = 1; e_tag = "R1";
    end else begin
      case (exc)
        5'd4: esc = !sc[1];
        5'd6: esc = !sc[2];
        5'd5: esc = !cs[3];
        5'd7: esc = !cs[4];
        default: esc = 0;
      endcase
      ts = bk ? sec : tg[exc[3:0]];
      if (esc) begin
        fe = 3; e_bank = sx && (ts || !hn); e_tag = "R4/R5";
      end else begin
        fe = int'(exc); e_bank = bk && sec;
      end
      e_exc = XW'(fe);
      en  = e_bank ? ens[fe] : enn[fe];
      pd  = e_bank ? pds[fe] : pdn[fe];
      gp  = e_bank ? gps[fe*PW +: PW] : gpn[fe*PW +: PW];
      blk = !en || (ep <= {1'b0, gp});
      if (blk && !cs[0]) begin
        e_lock = 1; e_tag = "R6";
      end else begin
        e_forced = esc;
        e_pend   = !pd;
      end
    end
  endtask

  task automatic run_req(input string tag);
    predict();
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " ", e_tag, " strobes"},
          {11'd0, pend_stb, forced_stb, ignore_stb, illegal_stb, lockup},
          {11'd0, e_pend, e_forced, e_ign, e_ill, e_lock});
    if (e_pend || e_forced)
      check({tag, " ", e_tag, " vector"}, {10'd0, pend_bank, pend_exc}, {10'd0, e_bank, e_exc});
  endtask

  task automatic base();
    exc = 5'd4; sec = 0; cs = 6'h3f; cn = 6'h3f; sx = 1; hn = 0; tg = '0;
    ens = '1; enn = '1; pds = '0; pdn = '0;
    gps = {N{8'h40}}; gpn = {N{8'h40}}; ep = 9'h100;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; e_lock = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    base();
    do_reset();
    // R10 reset state
    check("R10 reset", {9'd0, pend_stb, forced_stb, ignore_stb, illegal_stb, lockup, pend_bank, pend_exc[0]}, 16'd0);
    check("R10 reset exc", {11'd0, pend_exc}, 16'd0);

    base(); exc = 12; cs[5] = 0;                 run_req("R1 monitor dropped");
    base(); exc = 12;                            run_req("R1 monitor pends bank0");
    base(); exc = 4; sec = 1; cs[1] = 0;         run_req("R2 mem secure copy escalates R4 secure bank");
    base(); exc = 4; sec = 0; cs[1] = 0;         run_req("R2 mem ns copy no escalate");
    base(); exc = 6; sec = 0; cn[2] = 0; sx = 0; run_req("R2 usage escalates R4 no sec ext");
    base(); exc = 5; cn[3] = 0;                  run_req("R3 bus ignores ns copy");
    base(); exc = 7; cs[4] = 0; hn = 1;          run_req("R3 secfault escalates R11 ns target R4 ns bank");
    base(); exc = 7; cs[4] = 0; hn = 1; tg[7] = 1; run_req("R11 secure target R4 secure bank");
    base(); exc = 5; cs[3] = 0; pds[3] = 1;      run_req("R5 forced while pending R7 no pend");
    base(); exc = 6; pdn[6] = 1;                 run_req("R7 already pending");
    base(); exc = 1;                             run_req("R8 reset number");
    base(); exc = 20;                            run_req("R8 out of range");
    base(); exc = 5; sec = 1;                    run_req("R8 secure on non-banked");
    base(); exc = 5; cs[3] = 0; cs[0] = 0; ens[3] = 0; run_req("R6 disabled HF lockup");
    base(); exc = 4;                             run_req("R9 lockup persists");
    base(); exc = 4; ep = 9'h40; cs[0] = 1;      run_req("R6 blocked but HF ready");
    do_reset();
    check("R9 R10 reset clears lockup", {15'd0, lockup}, 16'd0);

    for (int i = 0; i < 600; i++) begin
      logic [XW-1:0] pick [8];
      pick = '{5'd1, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd12, 5'd20};
      if (i == 300) do_reset();
      exc = pick[$urandom % 8];
      sec = ($urandom % 3 == 0);
      cs  = 6'($urandom); cn = 6'($urandom);
      cs[0] = ($urandom % 8 != 0);
      sx  = 1'($urandom); hn = 1'($urandom);
      tg  = N'($urandom);
      ens = N'($urandom) | N'($urandom); enn = N'($urandom) | N'($urandom);
      pds = N'($urandom) & N'($urandom); pdn = N'($urandom) & N'($urandom);
      for (int k = 0; k < N; k++) begin
        gps[k*PW +: PW] = PW'($urandom);
        gpn[k*PW +: PW] = PW'($urandom);
      end
      ep = (PW+1)'($urandom);
      run_req("random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule